// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is the integer register file of a RISC core. Software names registers with a 5-bit number. Numbers 0 to 7 are globals, and every window sees the same globals. Numbers 8 to 31 belong to a window and are moved through a current-window pointer onto a ring of windowed registers. Each window has 16 registers of its own. Neighbouring windows overlap by eight registers, so a caller's outgoing registers are the same storage as the callee's incoming registers.

The block has two combinational read ports and one write port that takes effect on the clock edge. A save command moves the pointer one window down and a restore command moves it one window up. The block checks each move against an 8-bit window-invalid mask. A move into a marked window is refused: the pointer stays where it is and an overflow or underflow flag is raised. Software loads the pointer and the mask directly. Neither one is defined after reset until it has been written.

None of the ports is a stream. Every port is a plain control or data pin that is sampled on each rising edge. There is no back-pressure and no handshake: a command applied in a cycle is always taken in that cycle.

Top module: `regwin_file`

## Requirements
- R1: Register numbers 1 to 7 are globals. A global written under one pointer value reads back the same value under every other pointer value.
- R2: Reading register number 0 returns zero on both read ports, and a write to number 0 is discarded.
- R3: Register number n (8 to 31) under pointer p uses windowed slot ((p*16)+(n-8)) mod 128. Numbers 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. The locals of each of the eight windows are private, so eight windows can hold eight different values in the same local number.
- R4: The ins of window W (numbers 24 to 31) are the outs of window W+1 (numbers 8 to 15). This holds at the same offset within each group.
- R5: The ring wraps. The ins of window 7 are the outs of window 0, a save from window 0 goes to window 7, and a restore from window 7 goes to window 0.
- R6: A save moves the pointer to (p-1) mod 8 when bit (p-1) mod 8 of the mask is clear. When that bit is set, the pointer is unchanged and the overflow flag is high for the one cycle after the command.
- R7: A restore moves the pointer to (p+1) mod 8 when bit (p+1) mod 8 of the mask is clear. When that bit is set, the pointer is unchanged and the underflow flag is high for the one cycle after the command.
- R8: The pointer field is 5 bits wide. Bits 4:3 always read as zero and ignore the values written to them. Bits 2:0 hold the window.
- R9: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle on.
- R10: The two read ports are independent and can read different registers in the same cycle.
- R11: In a single cycle, a direct pointer write wins over save and restore, and save wins over restore. At most one of the two flags is high.
- R12: A direct write of the pointer or the mask can be read back on its output from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the flags only |
| rd_a_num | input | 5 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_num | input | 5 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_num | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| cwp_wr_en | input | 1 | Load the window pointer |
| cwp_wr_val | input | 5 | Pointer value to load (bits 4:3 ignored) |
| cwp_q | output | 5 | Current window pointer, bits 4:3 zero |
| wim_wr_en | input | 1 | Load the window-invalid mask |
| wim_wr_val | input | 8 | Mask value to load |
| wim_q | output | 8 | Current window-invalid mask |
| save_req | input | 1 | Move to the window below |
| restore_req | input | 1 | Move to the window above |
| ovf_flag | output | 1 | Save refused (one cycle) |
| unf_flag | output | 1 | Restore refused (one cycle) |

## Verification
The assertions assume that the pointer and the mask have been written before any save, restore or windowed access relies on them. Until then their contents are not defined, and the properties only compare these registers with their own earlier values. They also assume that the pointer stays unchanged between a write and the read that checks it. The stimulus loads both registers right after reset, before anything else, and it changes the pointer only through the dedicated pointer-write and save/restore tasks, never in the same cycle as a data write that is checked later.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  parameter int RW_DATA_W  = 32;
  parameter int RW_NUM_W   = 5;
  parameter int RW_NGLOB   = 8;
  parameter int RW_NWIN    = 8;
  parameter int RW_CWP_W   = 5;

  typedef enum logic [1:0] {
    MV_NONE    = 2'd0,
    MV_DOWN    = 2'd1,
    MV_UP      = 2'd2,
    MV_LOAD    = 2'd3
  } move_e;
endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate #(
  parameter int NUM_W    = 5,
  parameter int NGLOB    = 8,
  parameter int NWIN     = 8,
  parameter int WIN_BITS = $clog2(NWIN),
  parameter int PHYS_W   = 8
) (
  input  logic [NUM_W-1:0]    num,
  input  logic [WIN_BITS-1:0] cwp,
  output logic [PHYS_W-1:0]   phys
);
  localparam int STEP    = 2 * NGLOB;
  localparam int STEP_SH = $clog2(STEP);
  localparam int WOFF_W  = WIN_BITS + STEP_SH;

  logic [WOFF_W-1:0] base;
  logic [WOFF_W-1:0] rel;
  logic [WOFF_W-1:0] woff;

  always_comb begin
    base = {cwp, {STEP_SH{1'b0}}};
    rel  = WOFF_W'(num - NUM_W'(NGLOB));
    woff = base + rel;
    if (num < NUM_W'(NGLOB)) phys = PHYS_W'(num);
    else                     phys = PHYS_W'(NGLOB) + PHYS_W'(woff);
  end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN     = 8,
  parameter int WIN_BITS = $clog2(NWIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cwp_wr_en,
  input  logic [WIN_BITS-1:0] cwp_wr_val,
  input  logic                wim_wr_en,
  input  logic [NWIN-1:0]     wim_wr_val,
  input  logic                save_req,
  input  logic                restore_req,
  output logic [WIN_BITS-1:0] cwp,
  output logic [NWIN-1:0]     wim,
  output logic                ovf_flag,
  output logic                unf_flag
);
  import regwin_pkg::*;

  logic [WIN_BITS-1:0] dn_win, up_win;
  logic                dn_bad, up_bad;
  move_e               mv;
  logic                ovf_d, unf_d;

  always_comb begin
    dn_win = cwp - 1'b1;
    up_win = cwp + 1'b1;
    dn_bad = wim[dn_win];
    up_bad = wim[up_win];
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    mv     = MV_NONE;
    if (cwp_wr_en) begin
      mv = MV_LOAD;
    end else if (save_req) begin
      if (dn_bad) ovf_d = 1'b1;
      else        mv    = MV_DOWN;
    end else if (restore_req) begin
      if (up_bad) unf_d = 1'b1;
      else        mv    = MV_UP;
    end
  end

  always_ff @(posedge clk) begin
    case (mv)
      MV_LOAD: cwp <= cwp_wr_val;
      MV_DOWN: cwp <= dn_win;
      MV_UP:   cwp <= up_win;
      default: cwp <= cwp;
    endcase
    if (wim_wr_en) wim <= wim_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_d;
      unf_flag <= unf_d;
    end
  end

  assert_save_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !cwp_wr_en && !wim[WIN_BITS'(cwp - 1'b1)])
      |=> (cwp == WIN_BITS'($past(cwp) - 1'b1)) && !ovf_flag);

  assert_save_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !cwp_wr_en && wim[WIN_BITS'(cwp - 1'b1)])
      |=> ovf_flag && $stable(cwp));

  assert_restore_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !cwp_wr_en && !wim[WIN_BITS'(cwp + 1'b1)])
      |=> (cwp == WIN_BITS'($past(cwp) + 1'b1)) && !unf_flag);

  assert_restore_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !cwp_wr_en && wim[WIN_BITS'(cwp + 1'b1)])
      |=> unf_flag && $stable(cwp));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_flag, unf_flag}));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_wr_en |=> (cwp == $past(cwp_wr_val)) && !ovf_flag && !unf_flag);

  assert_quiet_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cwp_wr_en && !save_req && !restore_req) |=> $stable(cwp));
endmodule

// File: rtl/regwin_array.sv
module regwin_array #(
  parameter int DATA_W = 32,
  parameter int NPHYS  = 136,
  parameter int PHYS_W = $clog2(NPHYS),
  parameter int NRD    = 2
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [PHYS_W-1:0]           widx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NRD-1:0][PHYS_W-1:0]  ridx,
  output logic [NRD-1:0][DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] regs [0:NPHYS-1];

  always_ff @(posedge clk) begin
    if (we && (widx != '0)) regs[widx] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    always_comb begin
      if (ridx[i] == '0) rdata[i] = '0;
      else               rdata[i] = regs[ridx[i]];
    end
  end
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W = regwin_pkg::RW_DATA_W,
  parameter int NUM_W  = regwin_pkg::RW_NUM_W,
  parameter int NGLOB  = regwin_pkg::RW_NGLOB,
  parameter int NWIN   = regwin_pkg::RW_NWIN,
  parameter int CWP_W  = regwin_pkg::RW_CWP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_W-1:0]  rd_a_num,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [NUM_W-1:0]  rd_b_num,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [NUM_W-1:0]  wr_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cwp_wr_en,
  input  logic [CWP_W-1:0]  cwp_wr_val,
  output logic [CWP_W-1:0]  cwp_q,
  input  logic              wim_wr_en,
  input  logic [NWIN-1:0]   wim_wr_val,
  output logic [NWIN-1:0]   wim_q,
  input  logic              save_req,
  input  logic              restore_req,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int WIN_BITS = $clog2(NWIN);
  localparam int NWREG    = NWIN * 2 * NGLOB;
  localparam int NPHYS    = NGLOB + NWREG;
  localparam int PHYS_W   = $clog2(NPHYS);
  localparam int NRD      = 2;
  localparam int NPORT    = NRD + 1;

  logic [WIN_BITS-1:0]              cwp;
  logic [NPORT-1:0][NUM_W-1:0]      port_num;
  logic [NPORT-1:0][PHYS_W-1:0]     port_phys;
  logic [NRD-1:0][PHYS_W-1:0]       rd_phys;
  logic [NRD-1:0][DATA_W-1:0]       rd_data;

  assign port_num = {wr_num, rd_b_num, rd_a_num};

  for (genvar i = 0; i < NPORT; i++) begin : g_map
    regwin_xlate #(
      .NUM_W(NUM_W), .NGLOB(NGLOB), .NWIN(NWIN),
      .WIN_BITS(WIN_BITS), .PHYS_W(PHYS_W)
    ) xlate_i (
      .num(port_num[i]), .cwp(cwp), .phys(port_phys[i])
    );
  end

  assign rd_phys = {port_phys[1], port_phys[0]};

  regwin_ptr #(.NWIN(NWIN), .WIN_BITS(WIN_BITS)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .cwp_wr_en(cwp_wr_en), .cwp_wr_val(cwp_wr_val[WIN_BITS-1:0]),
    .wim_wr_en(wim_wr_en), .wim_wr_val(wim_wr_val),
    .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp), .wim(wim_q),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  regwin_array #(
    .DATA_W(DATA_W), .NPHYS(NPHYS), .PHYS_W(PHYS_W), .NRD(NRD)
  ) array_i (
    .clk(clk), .we(wr_en), .widx(port_phys[NRD]), .wdata(wr_data),
    .ridx(rd_phys), .rdata(rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign cwp_q     = CWP_W'(cwp);

  assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_num == '0) |-> (rd_a_data == '0));

  assert_global_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_num != '0) && (wr_num < NUM_W'(NGLOB)))
      |=> (rd_a_num != $past(wr_num)) || (rd_a_data == $past(wr_data)));

  assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_num != '0) && !cwp_wr_en && !save_req && !restore_req)
      |=> (rd_b_num != $past(wr_num)) || (rd_b_data == $past(wr_data)));

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cwp_wr_en && !save_req && !restore_req && $stable(rd_a_num))
      |=> $stable(rd_a_data));
endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_num = '0, rd_b_num = '0, wr_num = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, cwp_wr_en = 1'b0, wim_wr_en = 1'b0;
  logic [4:0]  cwp_wr_val = '0, cwp_q;
  logic [7:0]  wim_wr_val = '0, wim_q;
  logic        save_req = 1'b0, restore_req = 1'b0;
  logic        ovf_flag, unf_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
    .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .cwp_wr_en(cwp_wr_en), .cwp_wr_val(cwp_wr_val), .cwp_q(cwp_q),
    .wim_wr_en(wim_wr_en), .wim_wr_val(wim_wr_val), .wim_q(wim_q),
    .save_req(save_req), .restore_req(restore_req),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    wr_en = 1'b1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cwp(input logic [4:0] v);
    cwp_wr_en = 1'b1; cwp_wr_val = v;
    @(negedge clk);
    cwp_wr_en = 1'b0;
  endtask

  task automatic set_wim(input logic [7:0] v);
    wim_wr_en = 1'b1; wim_wr_val = v;
    @(negedge clk);
    wim_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, output logic [31:0] d);
    rd_a_num = n; #1; d = rd_a_data;
  endtask

  task automatic cmd(input logic sv, input logic rs);
    save_req = sv; restore_req = rs;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R6 ovf after reset", 32'(ovf_flag), 0);
    chk("R7 unf after reset", 32'(unf_flag), 0);
    rd(5'd0, d); chk("R2 r0 after reset", d, 0);
  endtask

  task automatic t_init();
    set_wim(8'h00); set_cwp(5'd0);
    chk("R12 wim load", 32'(wim_q), 0);
    chk("R12 cwp load", 32'(cwp_q), 0);
    set_wim(8'hA5);
    chk("R12 wim readback", 32'(wim_q), 32'hA5);
    set_wim(8'h00);
  endtask

  task automatic t_globals();
    logic [31:0] d;
    set_cwp(5'd2); wr(5'd5, 32'h6A6A0005);
    set_cwp(5'd6); rd(5'd5, d); chk("R1 global across windows", d, 32'h6A6A0005);
    wr(5'd7, 32'h77); set_cwp(5'd1); rd(5'd7, d); chk("R1 global r7", d, 32'h77);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d); chk("R2 r0 write discarded A", d, 0);
    rd_b_num = 5'd0; #1; chk("R2 r0 port B", rd_b_data, 0);
  endtask

  task automatic t_locals();
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      set_cwp(5'(w)); wr(5'd17, 32'h100 + 32'(w));
    end
    for (int w = 0; w < 8; w++) begin
      set_cwp(5'(w)); rd(5'd17, d);
      chk($sformatf("R3 local private w%0d", w), d, 32'h100 + 32'(w));
    end
  endtask

  task automatic t_overlap();
    logic [31:0] d;
    set_cwp(5'd3); wr(5'd26, 32'hB0B0_0026);
    set_cwp(5'd4); rd(5'd10, d); chk("R4 ins W3 = outs W4", d, 32'hB0B0_0026);
    wr(5'd12, 32'hC0C0_0012);
    cmd(1'b1, 1'b0);
    chk("R6 save moves to 3", 32'(cwp_q), 3);
    chk("R6 no ovf", 32'(ovf_flag), 0);
    rd(5'd28, d); chk("R4 callee ins = caller outs", d, 32'hC0C0_0012);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    set_cwp(5'd7); wr(5'd30, 32'hD0D0_0030);
    set_cwp(5'd0); rd(5'd14, d); chk("R5 ins W7 = outs W0", d, 32'hD0D0_0030);
    cmd(1'b1, 1'b0); chk("R5 save wraps 0->7", 32'(cwp_q), 7);
    cmd(1'b0, 1'b1); chk("R5 restore wraps 7->0", 32'(cwp_q), 0);
  endtask

  task automatic t_ovf();
    set_wim(8'h04); set_cwp(5'd3);
    cmd(1'b1, 1'b0);
    chk("R6 ovf raised", 32'(ovf_flag), 1);
    chk("R6 cwp held", 32'(cwp_q), 3);
    @(negedge clk); #1;
    chk("R6 ovf one cycle", 32'(ovf_flag), 0);
    set_wim(8'h00);
  endtask

  task automatic t_unf();
    set_wim(8'h20); set_cwp(5'd4);
    cmd(1'b0, 1'b1);
    chk("R7 unf raised", 32'(unf_flag), 1);
    chk("R7 cwp held", 32'(cwp_q), 4);
    set_wim(8'h00);
    chk("R7 unf one cycle", 32'(unf_flag), 0);
    cmd(1'b0, 1'b1);
    chk("R7 restore moves to 5", 32'(cwp_q), 5);
  endtask

  task automatic t_field();
    set_cwp(5'b11110);
    chk("R8 high bits read zero", 32'(cwp_q), 6);
  endtask

  task automatic t_rdw();
    logic [31:0] d;
    set_cwp(5'd1); wr(5'd20, 32'hEEEE_0020);
    wr_en = 1'b1; wr_num = 5'd20; wr_data = 32'hFFFF_0020;
    rd(5'd20, d); chk("R9 same-cycle read old", d, 32'hEEEE_0020);
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R9 new value next cycle", rd_a_data, 32'hFFFF_0020);
  endtask

  task automatic t_dual();
    rd_a_num = 5'd20; rd_b_num = 5'd5; #1;
    chk("R10 port A", rd_a_data, 32'hFFFF_0020);
    chk("R10 port B", rd_b_data, 32'h6A6A0005);
  endtask

  task automatic t_prio();
    set_cwp(5'd4);
    cwp_wr_en = 1'b1; cwp_wr_val = 5'd2;
    cmd(1'b1, 1'b0); cwp_wr_en = 1'b0;
    chk("R11 pointer write beats save", 32'(cwp_q), 2);
    set_cwp(5'd4);
    cmd(1'b1, 1'b1);
    chk("R11 save beats restore", 32'(cwp_q), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    @(negedge clk);
    t_init();
    t_globals();
    t_zero();
    t_locals();
    t_overlap();
    t_wrap();
    t_ovf();
    t_unf();
    t_field();
    t_rdw();
    t_dual();
    t_prio();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule